// File: doc/BRIEF.md
# Sleep Mode and Clock Gating Controller

This block decides when a small processor core may sleep and which of its clock domains stay alive while it does. The core raises a one-cycle sleep request when it executes its sleep instruction; the controller honours it only when the sleep-enable control bit is set. It then latches the 3-bit mode field and drives six registered enables: CPU clock, flash clock, I/O clock, ADC clock, asynchronous-timer clock and main oscillator.

While asleep, the controller compares the pending wake sources against the set of sources the latched mode accepts. A qualified source starts the wake sequence. First comes an oscillator start-up wait, whose length depends on the mode. Then comes a fixed four-cycle halt with the CPU clock still stopped. After that the CPU clock returns together with a one-cycle resume pulse, so the core can service the interrupt and carry on after its sleep instruction. Register and memory contents are untouched because only enables are gated. A core reset seen during sleep takes the reset path instead: it waits out the start-up time, skips the halt and gives a reset-resume pulse.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After rstN is released all six enables are 1 and both resume outputs are 0.
- R2: A sleepReq while sleepEn is 0 is ignored: the CPU clock enable stays 1 and the other enables do not change.
- R3: One cycle after an accepted request, the enables {cpu,flash,io,adc,asy,osc} take the mode's pattern. Idle 000 gives 001111. ADC noise reduction 001 gives 000111. Power-down 010 gives 000000. Power-save 011 gives 000010. Standby 110 gives 000001. Extended standby 111 gives 000011. The reserved codes 100 and 101 act as Idle.
- R4: In Idle, every wake source ends sleep, including otherIo. In ADC noise reduction, otherIo is not a wake source but the ADC interrupt is. In power-down, edge-configured interrupts, ADC, NVM-ready and otherIo are all ignored.
- R5: An edge-configured external interrupt (wakeExtEdge) wakes the core only in Idle. In the other modes only the level-configured input (wakeExtLevel) wakes it.
- R6: Outside Idle, wakeTimer wakes the core only in modes that accept it, and only while timerAsync is 1. Power-down and standby never accept it.
- R7: The start-up wait is startupCycles cycles in power-down and power-save, STBY_CYCLES cycles in standby and extended standby, and zero cycles in Idle and ADC noise reduction. A startupCycles value of 0 means no wait.
- R8: After the start-up wait come exactly 4 halt cycles. During these, cpu and flash are 0 and io, adc, asy and osc are 1. Then cpuClkEn returns to 1 together with a resumeIrq pulse lasting one cycle.
- R9: A coreReset during sleep, start-up or halt ends the sequence after the start-up wait with no halt. It raises resumeReset and never resumeIrq. It takes priority over a wake source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rstN | input | 1 | Asynchronous active-low reset of the controller |
| sleepReq | input | 1 | One-cycle pulse from the CPU's sleep instruction |
| sleepEn | input | 1 | Sleep-enable control bit |
| modeSel | input | 3 | Sleep mode code |
| startupCycles | input | CNT_W | Oscillator start-up length for the modes that stop the oscillator |
| timerAsync | input | 1 | Asynchronous timer runs from its own oscillator |
| wakeExtLevel | input | 1 | Level-configured external interrupt pending |
| wakeExtEdge | input | 1 | Edge-configured external interrupt pending |
| wakePinChg | input | 1 | Pin-change interrupt pending |
| wakeAddrMatch | input | 1 | Serial-bus address match pending |
| wakeTimer | input | 1 | Asynchronous timer interrupt pending |
| wakeNvmReady | input | 1 | Flash/EEPROM ready interrupt pending |
| wakeAdc | input | 1 | ADC conversion-complete interrupt pending |
| wakeWdt | input | 1 | Watchdog interrupt pending |
| wakeOtherIo | input | 1 | Any other I/O interrupt pending |
| coreReset | input | 1 | Reset event for the core |
| cpuClkEn | output | 1 | CPU clock enable |
| flashClkEn | output | 1 | Flash clock enable |
| ioClkEn | output | 1 | I/O clock enable |
| adcClkEn | output | 1 | ADC clock enable |
| asyClkEn | output | 1 | Asynchronous timer clock enable |
| oscEn | output | 1 | Main oscillator enable |
| resumeIrq | output | 1 | One-cycle pulse: the core resumes into the interrupt |
| resumeReset | output | 1 | One-cycle pulse: the core restarts from reset |

## Verification
Two events can collide in one cycle: a qualified wake source and a core reset. The bench drives both on the same clock edge while the block sits in standby. It then expects the reset path: the standby start-up length, no halt window with the I/O clock on, a resumeReset pulse and no resumeIrq. A second case drives the reset alone in power-down, which separates the priority rule from the plain reset path.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'b000,
    MD_ADCNR = 3'b001,
    MD_PDOWN = 3'b010,
    MD_PSAVE = 3'b011,
    MD_RSV4  = 3'b100,
    MD_RSV5  = 3'b101,
    MD_STBY  = 3'b110,
    MD_XSTBY = 3'b111
  } sleepMode_e;

  typedef enum logic [1:0] {PH_RUN, PH_SLEEP, PH_START, PH_HALT} phase_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic io;
    logic adc;
    logic asy;
    logic osc;
  } clkEn_t;

  typedef struct packed {
    logic extLevel;
    logic extEdge;
    logic pinChg;
    logic addrMatch;
    logic timer;
    logic nvmReady;
    logic adc;
    logic wdt;
    logic otherIo;
  } wakeSrc_t;

  typedef struct packed {
    logic   latchMode;
    logic   loadStart;
    logic   loadHalt;
    logic   countDown;
    logic   resumeIrq;
    logic   resumeReset;
    phase_e phase;
  } strobe_t;

  localparam int HALT_CYCLES = 4;

  function automatic sleepMode_e normMode(logic [2:0] code);
    if (code == 3'b100 || code == 3'b101) return MD_IDLE;
    return sleepMode_e'(code);
  endfunction

  function automatic clkEn_t sleepMask(sleepMode_e m);
    case (m)
      MD_ADCNR: return clkEn_t'(6'b000111);
      MD_PDOWN: return clkEn_t'(6'b000000);
      MD_PSAVE: return clkEn_t'(6'b000010);
      MD_STBY:  return clkEn_t'(6'b000001);
      MD_XSTBY: return clkEn_t'(6'b000011);
      default:  return clkEn_t'(6'b001111);
    endcase
  endfunction

  function automatic logic wakeQualify(sleepMode_e m, wakeSrc_t s, logic timerAsync);
    logic common;
    common = s.extLevel | s.pinChg | s.addrMatch | s.wdt;
    case (m)
      MD_ADCNR:         return common | (s.timer & timerAsync) | s.nvmReady | s.adc;
      MD_PDOWN, MD_STBY: return common;
      MD_PSAVE, MD_XSTBY: return common | (s.timer & timerAsync);
      default:          return |s;
    endcase
  endfunction

endpackage

// File: rtl/pwr_ctrl.sv
module pwr_ctrl
  import pwr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sleepReq,
  input  logic    sleepEn,
  input  logic    coreReset,
  input  logic    wakeHit,
  input  logic    cntLast,
  input  logic    startZero,
  output strobe_t strobe
);

  phase_e stateQ;
  logic   rstFlagQ;
  logic   rstFlagNext;

  always_comb begin
    strobe       = '0;
    strobe.phase = stateQ;
    rstFlagNext  = rstFlagQ;
    case (stateQ)
      PH_RUN: begin
        if (sleepReq && sleepEn) begin
          strobe.latchMode = 1'b1;
          strobe.phase     = PH_SLEEP;
        end
      end
      PH_SLEEP: begin
        if (coreReset) begin
          rstFlagNext = 1'b1;
          if (startZero) begin
            strobe.phase       = PH_RUN;
            strobe.resumeReset = 1'b1;
          end else begin
            strobe.phase     = PH_START;
            strobe.loadStart = 1'b1;
          end
        end else if (wakeHit) begin
          if (startZero) begin
            strobe.phase    = PH_HALT;
            strobe.loadHalt = 1'b1;
          end else begin
            strobe.phase     = PH_START;
            strobe.loadStart = 1'b1;
          end
        end
      end
      PH_START: begin
        if (coreReset) rstFlagNext = 1'b1;
        if (cntLast) begin
          if (rstFlagQ || coreReset) begin
            strobe.phase       = PH_RUN;
            strobe.resumeReset = 1'b1;
          end else begin
            strobe.phase    = PH_HALT;
            strobe.loadHalt = 1'b1;
          end
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      PH_HALT: begin
        if (coreReset) begin
          strobe.phase       = PH_RUN;
          strobe.resumeReset = 1'b1;
        end else if (cntLast) begin
          strobe.phase     = PH_RUN;
          strobe.resumeIrq = 1'b1;
        end else begin
          strobe.countDown = 1'b1;
        end
      end
      default: strobe.phase = PH_RUN;
    endcase
    if (strobe.phase == PH_RUN) rstFlagNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= PH_RUN;
      rstFlagQ <= 1'b0;
    end else begin
      stateQ   <= strobe.phase;
      rstFlagQ <= rstFlagNext;
    end
  end

endmodule

// File: rtl/pwr_datapath.sv
module pwr_datapath
  import pwr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STBY_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [2:0]       modeSel,
  input  logic [CNT_W-1:0] startupCycles,
  input  wakeSrc_t         wakeSrc,
  input  logic             timerAsync,
  output logic             wakeHit,
  output logic             cntLast,
  output logic             startZero,
  output clkEn_t           clkEn,
  output logic             resumeIrq,
  output logic             resumeReset
);

  localparam logic [CNT_W-1:0] STBY_LOAD = CNT_W'(STBY_CYCLES);
  localparam logic [CNT_W-1:0] HALT_LOAD = CNT_W'(HALT_CYCLES);

  sleepMode_e       modeQ;
  sleepMode_e       modeNext;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] startVal;
  clkEn_t           clkEnNext;
  clkEn_t           startMask;

  assign modeNext = strobe.latchMode ? normMode(modeSel) : modeQ;

  always_comb begin
    case (modeQ)
      MD_PDOWN, MD_PSAVE: startVal = startupCycles;
      MD_STBY, MD_XSTBY:  startVal = STBY_LOAD;
      default:            startVal = '0;
    endcase
  end

  assign startZero = (startVal == '0);
  assign cntLast   = (cntQ == CNT_W'(1));
  assign wakeHit   = wakeQualify(modeQ, wakeSrc, timerAsync);

  always_comb begin
    startMask     = sleepMask(modeNext);
    startMask.osc = 1'b1;
    case (strobe.phase)
      PH_SLEEP: clkEnNext = sleepMask(modeNext);
      PH_START: clkEnNext = startMask;
      PH_HALT:  clkEnNext = clkEn_t'(6'b001111);
      default:  clkEnNext = clkEn_t'(6'b111111);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= MD_IDLE;
      cntQ        <= '0;
      clkEn       <= clkEn_t'(6'b111111);
      resumeIrq   <= 1'b0;
      resumeReset <= 1'b0;
    end else begin
      modeQ       <= modeNext;
      clkEn       <= clkEnNext;
      resumeIrq   <= strobe.resumeIrq;
      resumeReset <= strobe.resumeReset;
      if (strobe.loadStart)      cntQ <= startVal;
      else if (strobe.loadHalt)  cntQ <= HALT_LOAD;
      else if (strobe.countDown) cntQ <= cntQ - CNT_W'(1);
    end
  end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STBY_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sleepReq,
  input  logic             sleepEn,
  input  logic [2:0]       modeSel,
  input  logic [CNT_W-1:0] startupCycles,
  input  logic             timerAsync,
  input  logic             wakeExtLevel,
  input  logic             wakeExtEdge,
  input  logic             wakePinChg,
  input  logic             wakeAddrMatch,
  input  logic             wakeTimer,
  input  logic             wakeNvmReady,
  input  logic             wakeAdc,
  input  logic             wakeWdt,
  input  logic             wakeOtherIo,
  input  logic             coreReset,
  output logic             cpuClkEn,
  output logic             flashClkEn,
  output logic             ioClkEn,
  output logic             adcClkEn,
  output logic             asyClkEn,
  output logic             oscEn,
  output logic             resumeIrq,
  output logic             resumeReset
);

  strobe_t  strobe;
  wakeSrc_t wakeSrc;
  clkEn_t   clkEn;
  logic     wakeHit;
  logic     cntLast;
  logic     startZero;

  assign wakeSrc = '{extLevel: wakeExtLevel, extEdge: wakeExtEdge, pinChg: wakePinChg,
                     addrMatch: wakeAddrMatch, timer: wakeTimer, nvmReady: wakeNvmReady,
                     adc: wakeAdc, wdt: wakeWdt, otherIo: wakeOtherIo};

  pwr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .sleepEn   (sleepEn),
    .coreReset (coreReset),
    .wakeHit   (wakeHit),
    .cntLast   (cntLast),
    .startZero (startZero),
    .strobe    (strobe)
  );

  pwr_datapath #(
    .CNT_W       (CNT_W),
    .STBY_CYCLES (STBY_CYCLES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .modeSel       (modeSel),
    .startupCycles (startupCycles),
    .wakeSrc       (wakeSrc),
    .timerAsync    (timerAsync),
    .wakeHit       (wakeHit),
    .cntLast       (cntLast),
    .startZero     (startZero),
    .clkEn         (clkEn),
    .resumeIrq     (resumeIrq),
    .resumeReset   (resumeReset)
  );

  assign cpuClkEn   = clkEn.cpu;
  assign flashClkEn = clkEn.flash;
  assign ioClkEn    = clkEn.io;
  assign adcClkEn   = clkEn.adc;
  assign asyClkEn   = clkEn.asy;
  assign oscEn      = clkEn.osc;

endmodule

// File: rtl/pwr_sleep_chk.sv
module pwr_sleep_chk (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic sleepEn,
  input logic cpuClkEn,
  input logic flashClkEn,
  input logic ioClkEn,
  input logic oscEn,
  input logic resumeIrq,
  input logic resumeReset
);

  AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn && sleepReq && !sleepEn |=> cpuClkEn); // R2

  AST_CPU_FLASH_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    flashClkEn == cpuClkEn); // R3

  AST_CPU_NEEDS_OSC: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |-> oscEn); // R7

  AST_HALT_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    resumeIrq |-> ($past(ioClkEn && !cpuClkEn, 1) && $past(ioClkEn && !cpuClkEn, 2) &&
                   $past(ioClkEn && !cpuClkEn, 3) && $past(ioClkEn && !cpuClkEn, 4))); // R8

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resumeIrq |=> !resumeIrq); // R8

  AST_RESUME_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(resumeIrq && resumeReset)); // R9

  AST_RESUME_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (resumeIrq || resumeReset) |-> (cpuClkEn && $past(!cpuClkEn))); // R9

endmodule

bind pwr_sleep_ctrl pwr_sleep_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sleepReq    (sleepReq),
  .sleepEn     (sleepEn),
  .cpuClkEn    (cpuClkEn),
  .flashClkEn  (flashClkEn),
  .ioClkEn     (ioClkEn),
  .oscEn       (oscEn),
  .resumeIrq   (resumeIrq),
  .resumeReset (resumeReset)
);

// File: tb/sim_pwr_sleep_ctrl.sv
module sim_pwr_sleep_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int STBY       = 6;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             sleepReq = 1'b0;
  logic             sleepEn = 1'b0;
  logic [2:0]       modeSel = 3'b000;
  logic [CNT_W-1:0] startupCycles = '0;
  logic             timerAsync = 1'b0;
  logic             wakeExtLevel = 1'b0, wakeExtEdge = 1'b0, wakePinChg = 1'b0;
  logic             wakeAddrMatch = 1'b0, wakeTimer = 1'b0, wakeNvmReady = 1'b0;
  logic             wakeAdc = 1'b0, wakeWdt = 1'b0, wakeOtherIo = 1'b0;
  logic             coreReset = 1'b0;
  logic             cpuClkEn, flashClkEn, ioClkEn, adcClkEn, asyClkEn, oscEn;
  logic             resumeIrq, resumeReset;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_sleep_ctrl #(.CNT_W(CNT_W), .STBY_CYCLES(STBY)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int maskNow();
    return int'({cpuClkEn, flashClkEn, ioClkEn, adcClkEn, asyClkEn, oscEn});
  endfunction

  task automatic clearWake();
    wakeExtLevel = 0; wakeExtEdge = 0; wakePinChg = 0; wakeAddrMatch = 0;
    wakeTimer = 0; wakeNvmReady = 0; wakeAdc = 0; wakeWdt = 0; wakeOtherIo = 0;
    coreReset = 0;
  endtask

  task automatic enterSleep(input logic [2:0] code, input int expMask, input string req);
    @(negedge clk);
    modeSel = code; sleepEn = 1; sleepReq = 1;
    @(negedge clk);
    sleepReq = 0; sleepEn = 0;
    chk(req, maskNow(), expMask);
  endtask

  task automatic stayAsleep(input int expMask, input string req);
    repeat (3) @(negedge clk);
    chk(req, maskNow(), expMask);
    clearWake();
  endtask

  // Stimulus already applied at this negedge; measures cycles until CPU returns.
  task automatic measureWake(input int expLen, input int expHalt, input bit expRst, input string req);
    int len = 0;
    int halt = 0;
    @(negedge clk);
    clearWake();
    while (!cpuClkEn && len < 5000) begin
      len++;
      if (ioClkEn) halt++;
      @(negedge clk);
    end
    chk({req, " wake length"}, len, expLen);
    chk({req, " halt cycles"}, halt, expHalt);
    chk({req, " resumeIrq"}, int'(resumeIrq), int'(!expRst));
    chk({req, " resumeReset"}, int'(resumeReset), int'(expRst));
    chk({req, " full enables"}, maskNow(), 63);
    @(negedge clk);
    chk({req, " pulse cleared"}, int'(resumeIrq | resumeReset), 0);
  endtask

  task automatic testReset();
    chk("R1 enables", maskNow(), 63);
    chk("R1 resume", int'(resumeIrq | resumeReset), 0);
  endtask

  task automatic testIgnoredReq();
    @(negedge clk);
    modeSel = 3'b010; sleepEn = 0; sleepReq = 1;
    @(negedge clk);
    sleepReq = 0;
    repeat (2) @(negedge clk);
    chk("R2 request without enable", maskNow(), 63);
  endtask

  task automatic testIdle();
    enterSleep(3'b000, 6'b001111, "R3 idle mask");
    wakeExtEdge = 1; // R5 edge input valid in idle
    measureWake(HALT_CYCLES_TB, 4, 0, "R8 idle via edge R5");
  endtask

  localparam int HALT_CYCLES_TB = 4;

  task automatic testReserved();
    enterSleep(3'b101, 6'b001111, "R3 reserved code as idle");
    wakeOtherIo = 1;
    measureWake(4, 4, 0, "R4 idle other io");
  endtask

  task automatic testAdcNr();
    enterSleep(3'b001, 6'b000111, "R3 adc noise mask");
    wakeOtherIo = 1;
    stayAsleep(6'b000111, "R4 adc noise ignores other io");
    wakeAdc = 1;
    measureWake(4, 4, 0, "R4 adc noise via adc");
  endtask

  task automatic testPowerDown();
    startupCycles = 10;
    timerAsync = 1;
    enterSleep(3'b010, 6'b000000, "R3 power-down mask");
    wakeExtEdge = 1; wakeAdc = 1; wakeNvmReady = 1; wakeOtherIo = 1; wakeTimer = 1;
    stayAsleep(6'b000000, "R4 R5 R6 power-down ignored sources");
    wakeExtLevel = 1;
    measureWake(14, 4, 0, "R7 power-down startup");
    timerAsync = 0;
  endtask

  task automatic testPowerSave();
    startupCycles = 7;
    enterSleep(3'b011, 6'b000010, "R3 power-save mask");
    wakeTimer = 1;
    stayAsleep(6'b000010, "R6 timer ignored when synchronous");
    timerAsync = 1; wakeTimer = 1;
    measureWake(11, 4, 0, "R6 power-save async timer");
    timerAsync = 0;
  endtask

  task automatic testStandby();
    enterSleep(3'b110, 6'b000001, "R3 standby mask");
    wakePinChg = 1;
    measureWake(STBY + 4, 4, 0, "R7 standby fixed startup");
  endtask

  task automatic testExtStandby();
    enterSleep(3'b111, 6'b000011, "R3 extended standby mask");
    wakeAddrMatch = 1;
    measureWake(STBY + 4, 4, 0, "R7 extended standby");
  endtask

  task automatic testZeroStartup();
    startupCycles = 0;
    enterSleep(3'b010, 6'b000000, "R3 power-down zero start");
    wakeWdt = 1;
    measureWake(4, 4, 0, "R7 zero startup");
  endtask

  task automatic testResetPath();
    startupCycles = 5;
    enterSleep(3'b010, 6'b000000, "R3 power-down before reset");
    coreReset = 1;
    measureWake(5, 0, 1, "R9 reset in power-down");
  endtask

  task automatic testResetWithWake();
    enterSleep(3'b110, 6'b000001, "R3 standby before collision");
    coreReset = 1; wakePinChg = 1;
    measureWake(STBY, 0, 1, "R9 reset beats wake");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testIgnoredReq();
    testIdle();
    testReserved();
    testAdcNr();
    testPowerDown();
    testPowerSave();
    testStandby();
    testExtStandby();
    testZeroStartup();
    testResetPath();
    testResetWithWake();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule